// File: doc/BRIEF.md
# Multi-Rate Lane Group Packer

This block gathers serial data from a group of eight single-bit lanes and assembles it into one 16-bit slot of a wide transmit frame, once per frame period. A rate-select input sets the lane speed to one, two or four times the base rate. At higher speeds fewer lanes carry data, each lane supplies more bits per frame, and the slot width stays fixed at 16 bits.

The block runs on a bit clock with eight ticks per frame period. The `frame_strobe` input marks tick 0 of each frame. Each lane shifts in its data most significant bit first. At every frame boundary the slot collected during the frame that just ended is handed over on `slot_out`, and `slot_valid` flags it. A new rate setting is taken over only at a frame boundary.

Top module: `elk_group_packer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `slot_out` is 0 and `slot_valid` is 0.
- R2: With `rate_sel` = 2'b00 (1x), all eight lanes are sampled, two bits each per frame. The slot is {lane7, lane6, ..., lane0}, two bits per lane, with each lane's earlier bit in the higher position.
- R3: With `rate_sel` = 2'b01 (2x), only lanes 6, 4, 2 and 0 are sampled, four bits each. The slot is {lane6, lane4, lane2, lane0}, with each lane's earliest bit in the highest of its four positions.
- R4: With `rate_sel` = 2'b10 (4x), only lanes 4 and 0 are sampled, eight bits each. The slot is {lane4, lane0}, with the earliest bit most significant.
- R5: A frame is 8 ticks long and tick 0 is the cycle in which `frame_strobe` is high. Lanes are sampled on ticks 0 and 4 at 1x, on even ticks at 2x, and on every tick at 4x. Values on other ticks have no effect.
- R6: Lanes that are unused at the current rate have no effect on `slot_out`.
- R7: At the clock edge where `frame_strobe` is sampled high, `slot_out` loads the slot of the frame that just ended. `slot_valid` is high for exactly the following cycle, and only after a strobe.
- R8: `slot_out` holds its value between frame strobes.
- R9: `rate_sel` is taken over only at a frame strobe, so a change and restore inside a frame has no effect. If the value taken at a strobe differs from the applied rate, the slot handed over at that strobe is loaded but not flagged valid.
- R10: The first frame strobe after reset produces no valid slot.
- R11: `rate_sel` = 2'b11 behaves exactly as 2'b00 (1x), including for rate-change detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane bit clock, eight ticks per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | High on tick 0 of each frame |
| rate_sel | input | 2 | Lane rate: 00 = 1x, 01 = 2x, 10 = 4x, 11 = 1x |
| lane_in | input | 8 | Serial lane inputs, index = lane number |
| slot_out | output | 16 | Packed slot of the last completed frame |
| slot_valid | output | 1 | One-cycle flag for a new valid slot |

## Verification
The hardest case to reach is the frame boundary where the rate changes. At that edge the old rate must still govern packing of the finished frame, while the new rate already decides which lanes take the tick-0 bit. The stimulus table changes rate between consecutive frames in both directions, and also moves from 2'b10 to the 2'b11 alias. Every one of these frames drives toggling junk on unused lanes and on non-sampled ticks, so a wrong lane choice or a wrong sampling phase shows up as corrupt slot data. A directed frame also changes `rate_sel` in mid-frame and restores it before the strobe.

// File: rtl/elk_pkg.sv
package elk_pkg;
   typedef enum logic [1:0] {
      RATE_X1 = 2'b00,
      RATE_X2 = 2'b01,
      RATE_X4 = 2'b10
   } rate_e;

   // The spare code 2'b11 is folded onto the base rate.
   function automatic rate_e norm_rate(input logic [1:0] code);
      return (code == 2'b11) ? RATE_X1 : rate_e'(code);
   endfunction
endpackage

// File: rtl/elk_phase_ctr.sv
module elk_phase_ctr
   import elk_pkg::*;
#(
   parameter int TICKS = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  frame_strobe,
   input  rate_e rate,
   output logic  sample
);
   localparam int PW = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [PW-1:0] MASK_X1 = PW'(3);
   localparam logic [PW-1:0] MASK_X2 = PW'(1);

   logic [PW-1:0] phase_q;
   logic [PW-1:0] phase_eff;
   logic [PW-1:0] mask;

   assign phase_eff = frame_strobe ? '0 : phase_q;

   always_comb begin
      case (rate)
         RATE_X2: mask = MASK_X2;
         RATE_X4: mask = '0;
         default: mask = MASK_X1;
      endcase
   end

   assign sample = ((phase_eff & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_eff + PW'(1);
   end
endmodule

// File: rtl/elk_lane_shifter.sv
module elk_lane_shifter #(
   parameter int SR_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            din,
   output logic [SR_W-1:0] sr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sr <= '0;
      else if (en) sr <= {sr[SR_W-2:0], din};
   end
endmodule

// File: rtl/elk_slot_pack.sv
module elk_slot_pack
   import elk_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int SLOT_W = 16,
   parameter int SR_W   = 8
) (
   input  logic [LANES-1:0][SR_W-1:0] sr,
   input  rate_e                      rate,
   output logic [SLOT_W-1:0]          slot
);
   localparam int BPL = SLOT_W / LANES;

   logic [2:0][SLOT_W-1:0] cand;

   for (genvar r = 0; r < 3; r++) begin : g_rate
      localparam int STRIDE = 1 << r;
      localparam int B      = BPL << r;
      localparam int N      = LANES >> r;
      for (genvar j = 0; j < N; j++) begin : g_lane
         assign cand[r][j*B +: B] = sr[j*STRIDE][B-1:0];
      end
   end

   always_comb begin
      case (rate)
         RATE_X2: slot = cand[1];
         RATE_X4: slot = cand[2];
         default: slot = cand[0];
      endcase
   end
endmodule

// File: rtl/elk_group_packer.sv
module elk_group_packer
   import elk_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int SLOT_W = 16,
   parameter int TICKS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_strobe,
   input  logic [1:0]        rate_sel,
   input  logic [LANES-1:0]  lane_in,
   output logic [SLOT_W-1:0] slot_out,
   output logic              slot_valid
);
   localparam int BPL  = SLOT_W / LANES;
   localparam int SR_W = BPL * 4;

   if (LANES % 4 != 0 || SLOT_W % LANES != 0) begin : g_bad_geom
      $error("elk_group_packer: LANES must divide by 4 and divide SLOT_W");
   end
   if (TICKS != SR_W || (TICKS & (TICKS - 1)) != 0) begin : g_bad_ticks
      $error("elk_group_packer: TICKS must be a power of two equal to 4*SLOT_W/LANES");
   end

   rate_e cur_rate;
   rate_e req_rate;
   rate_e rate_eff;
   logic  primed;
   logic  sample;
   logic [LANES-1:0]            lane_en;
   logic [LANES-1:0][SR_W-1:0]  sr;
   logic [SLOT_W-1:0]           packed_slot;

   assign req_rate = norm_rate(rate_sel);
   assign rate_eff = frame_strobe ? req_rate : cur_rate;

   elk_phase_ctr #(.TICKS(TICKS)) u_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_strobe (frame_strobe),
      .rate         (rate_eff),
      .sample       (sample)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic act;
      always_comb begin
         case (rate_eff)
            RATE_X2: act = (i % 2 == 0);
            RATE_X4: act = (i % 4 == 0);
            default: act = 1'b1;
         endcase
      end
      assign lane_en[i] = sample & act;

      elk_lane_shifter #(.SR_W(SR_W)) u_shift (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (lane_en[i]),
         .din   (lane_in[i]),
         .sr    (sr[i])
      );
   end

   elk_slot_pack #(.LANES(LANES), .SLOT_W(SLOT_W), .SR_W(SR_W)) u_pack (
      .sr   (sr),
      .rate (cur_rate),
      .slot (packed_slot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_rate   <= RATE_X1;
         primed     <= 1'b0;
         slot_out   <= '0;
         slot_valid <= 1'b0;
      end else begin
         slot_valid <= 1'b0;
         if (frame_strobe) begin
            cur_rate   <= req_rate;
            primed     <= 1'b1;
            if (primed) slot_out <= packed_slot;
            slot_valid <= primed && (req_rate == cur_rate);
         end
      end
   end
endmodule

// File: rtl/elk_group_packer_chk.sv
module elk_group_packer_chk
   import elk_pkg::*;
#(
   parameter int SLOT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_strobe,
   input logic [1:0]        rate_sel,
   input logic [SLOT_W-1:0] slot_out,
   input logic              slot_valid,
   input logic [1:0]        cur_rate,
   input logic              primed
);
   assert_valid_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid |-> $past(frame_strobe));

   assert_slot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_strobe) |-> $stable(slot_out));

   assert_rate_change_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_strobe && (norm_rate(rate_sel) != rate_e'(cur_rate))) |=> !slot_valid);

   assert_rate_only_at_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_strobe |=> $stable(cur_rate));

   assert_first_strobe_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_strobe && !primed) |=> !slot_valid);

   assert_rate_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cur_rate != 2'b11);
endmodule

bind elk_group_packer elk_group_packer_chk #(.SLOT_W(SLOT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_strobe (frame_strobe),
   .rate_sel     (rate_sel),
   .slot_out     (slot_out),
   .slot_valid   (slot_valid),
   .cur_rate     (cur_rate),
   .primed       (primed)
);

// File: tb/sim_elk_group_packer.sv
module sim_elk_group_packer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_strobe = 1'b0;
   logic [1:0]  rate_sel = 2'b00;
   logic [7:0]  lane_in = '0;
   logic [15:0] slot_out;
   logic        slot_valid;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [15:0] prev_data;
   int          prev_rate;
   bit          have_prev;

   always #2 clk = ~clk;

   elk_group_packer u0 (
      .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
      .rate_sel(rate_sel), .lane_in(lane_in),
      .slot_out(slot_out), .slot_valid(slot_valid)
   );

   // {rate_sel, slot data, noise}
   localparam logic [25:0] VEC [8] = '{
      {2'b00, 16'hA5C3, 8'h00},
      {2'b00, 16'h1234, 8'h00},
      {2'b01, 16'hF00F, 8'hFF},
      {2'b01, 16'h6B29, 8'hAA},
      {2'b10, 16'h8001, 8'h55},
      {2'b10, 16'hC35A, 8'hFF},
      {2'b11, 16'h7E81, 8'h3C},
      {2'b00, 16'h0FF0, 8'h00}
   };

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int norm(input logic [1:0] c);
      return (c == 2'b11) ? 0 : int'(c);
   endfunction

   function automatic string rate_req(input int r);
      if (r == 1) return "R3 R5 R6";
      if (r == 2) return "R4 R5 R6";
      return "R2 R5";
   endfunction

   // Lane values for tick t, derived from the packing rules of R2-R5.
   function automatic logic [7:0] lane_vec(input int r, input logic [15:0] d, input int t, input logic [7:0] noise);
      logic [7:0] v;
      int step, b, j, k;
      step = 4 >> r;
      b    = 2 << r;
      for (int l = 0; l < 8; l++) begin
         if ((l % (1 << r)) == 0 && (t % step) == 0) begin
            j = l >> r;
            k = t / step;
            v[l] = d[j*b + b - 1 - k];
         end else begin
            v[l] = noise[l] ^ t[0];
         end
      end
      return v;
   endfunction

   task automatic run_frame(input logic [1:0] rs, input logic [15:0] d, input logic [7:0] noise,
                            input bit use_glitch, input logic [1:0] glitch);
      int r;
      logic [15:0] held;
      r = norm(rs);
      for (int t = 0; t < 8; t++) begin
         @(negedge clk);
         frame_strobe = (t == 0);
         rate_sel     = (use_glitch && t >= 2 && t <= 5) ? glitch : rs;
         lane_in      = lane_vec(r, d, t, noise);
         @(posedge clk);
         #1;
         if (t == 0) begin
            held = slot_out;
            if (!have_prev) begin
               chk(slot_valid == 1'b0, "R10 first strobe valid", {15'd0, slot_valid}, 16'd0);
            end else if (r != prev_rate) begin
               chk(slot_valid == 1'b0, "R9 rate change valid", {15'd0, slot_valid}, 16'd0);
               chk(slot_out == prev_data, "R9 data at rate change", slot_out, prev_data);
            end else begin
               chk(slot_valid == 1'b1, "R7 valid pulse", {15'd0, slot_valid}, 16'd1);
               chk(slot_out == prev_data, rate_req(prev_rate), slot_out, prev_data);
            end
         end else if (t == 1) begin
            chk(slot_valid == 1'b0, "R7 valid one cycle", {15'd0, slot_valid}, 16'd0);
         end else if (t == 7) begin
            chk(slot_out == held, "R8 slot hold", slot_out, held);
         end
      end
      prev_data = d;
      prev_rate = r;
      have_prev = 1;
   endtask

   initial begin
      have_prev = 0;
      repeat (3) @(posedge clk);
      #1;
      chk(slot_out == 16'd0 && slot_valid == 1'b0, "R1 reset", slot_out, 16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(slot_out == 16'd0 && slot_valid == 1'b0, "R1 after release", slot_out, 16'd0);

      for (int i = 0; i < 8; i++) begin
         run_frame(VEC[i][25:24], VEC[i][23:8], VEC[i][7:0], 1'b0, 2'b00);
      end
      // R11: 2'b11 data 7E81 was checked as 1x; 11 -> 00 raised no rate change.

      // R9: rate_sel moved to 4x mid-frame and restored before the strobe.
      run_frame(2'b00, 16'h9669, 8'h00, 1'b1, 2'b10);
      run_frame(2'b00, 16'h5AA5, 8'h00, 1'b0, 2'b00);
      run_frame(2'b01, 16'h0000, 8'hF0, 1'b0, 2'b00);

      // R1: reset in mid-run clears the outputs.
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(slot_out == 16'd0 && slot_valid == 1'b0, "R1 mid-run reset", slot_out, 16'd0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule